// File: doc/BRIEF.md
# Segmented DMA Transfer Sequencer

This block sits between an SPI slave protocol engine and the slave's memory. It runs the slave's DMA read and write streams in segmented mode. Firmware posts a read buffer (a base address and a byte length) for the master to fetch, or a receive buffer for the master to fill. The master then moves that buffer in as many read or write transactions as it likes, each of any size. The block keeps its position from one transaction to the next. A logical transfer does not end at chip-select. It ends only when the protocol engine forwards an in-band termination command: 0x07 closes the write stream and 0x08 closes the read stream. On that command the block reports completion to the host side and makes the next posted buffer of that direction current.

Each direction has one current buffer and one pending buffer. The host posts a new buffer through a load/ready handshake. A read beyond the current length, or with no current buffer, returns the filler byte 0x00 and flags it as filler. A write beyond the current length, or with no current buffer, is dropped and sets a sticky overflow flag. The write-done event carries the number of bytes the master sent since the previous write termination.

Top module: `seg_dma_seq`

## Requirements
- R1: After a synchronous reset: neither direction holds a buffer, both host ready outputs are 1, and `rd_vld`, `rd_done`, `wr_done`, `wrmem_en` and `wr_overflow` are 0.
- R2: A read request that lands while the current read buffer has bytes left returns the byte at memory address (base + offset) mod 2^ADDR_W, one cycle after the request, with `rd_vld`=1 and `rd_fill`=0. The offset starts at 0 and advances by one per request. Idle gaps between transactions do not reset it.
- R3: Once the offset has reached the loaded length, every further read returns `rd_data`=0x00 with `rd_fill`=1.
- R4: A read with no current read buffer returns 0x00 with `rd_fill`=1, and the offset does not advance.
- R5: Command 0x08 pulses `rd_done` for exactly one cycle, in the cycle after the command. It resets the read offset to 0 and makes the pending read buffer current in that same cycle. With no pending buffer, the read stream is left without a buffer.
- R6: A write byte accepted into the current write buffer appears one cycle later as `wrmem_en`=1, with `wrmem_addr` = (base + offset) mod 2^ADDR_W and `wrmem_data` equal to the byte. The offset advances per accepted byte and persists across transactions.
- R7: A write byte with no current write buffer, or beyond its length, produces no `wrmem_en`. It sets `wr_overflow`, which then stays 1 until reset.
- R8: Command 0x07 pulses `wr_done` for one cycle, in the cycle after the command. `wr_done_count` carries the count of all write bytes received since the previous 0x07, dropped ones included. The count and the write offset then restart from 0, and the pending write buffer becomes current.
- R9: A host ready output is 0 while that direction's pending slot is occupied. A load while ready is 0 is ignored. A load into an idle direction becomes the current buffer two cycles after the load.
- R10: Command codes other than 0x07 and 0x08 change no state and produce no done pulse.
- R11: The directions are independent. Command 0x08 does not move the write offset or count, and command 0x07 does not move the read offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command byte from the protocol engine is present |
| cmd_code | input | 8 | Command byte (0x07 ends writes, 0x08 ends reads) |
| rd_req | input | 1 | Master requests the next read byte |
| rd_data | output | 8 | Read byte, one cycle after the request |
| rd_vld | output | 1 | `rd_data` is valid |
| rd_fill | output | 1 | `rd_data` is a filler byte |
| wr_valid | input | 1 | Master supplies a write byte |
| wr_byte | input | 8 | Write byte |
| host_rd_load | input | 1 | Host posts a read buffer |
| host_rd_base | input | ADDR_W | Base address of the posted read buffer |
| host_rd_len | input | LEN_W | Length in bytes of the posted read buffer |
| host_rd_ready | output | 1 | Read pending slot is free |
| host_wr_load | input | 1 | Host posts a receive buffer |
| host_wr_base | input | ADDR_W | Base address of the posted receive buffer |
| host_wr_len | input | LEN_W | Length in bytes of the posted receive buffer |
| host_wr_ready | output | 1 | Write pending slot is free |
| rd_done | output | 1 | Read termination event |
| wr_done | output | 1 | Write termination event |
| wr_done_count | output | CNT_W | Bytes written since the previous write termination (saturating) |
| wr_overflow | output | 1 | Sticky: a write byte was dropped |
| rdmem_addr | output | ADDR_W | Read-side memory address (combinational) |
| rdmem_data | input | 8 | Memory byte at `rdmem_addr`, same cycle |
| wrmem_en | output | 1 | Memory write strobe |
| wrmem_addr | output | ADDR_W | Memory write address |
| wrmem_data | output | 8 | Memory write byte |

## Verification
The bench builds the block with ADDR_W=6, LEN_W=7 and CNT_W=8, so the whole address space is 64 bytes. A receive buffer placed at base 60 therefore wraps through address 0 within a few bytes. The bench's memory model returns an arithmetic function of the address, so every expected read byte can be computed directly. A sweep over buffer lengths 1 to 6, each read two bytes past its end, reaches the valid-to-filler boundary at every position. The bench also interleaves read and write terminations in the middle of transactions to show that the two directions stay independent.

// File: rtl/seg_dma_pkg.sv
package seg_dma_pkg;

    localparam logic [7:0] CMD_WR_TERM = 8'h07;
    localparam logic [7:0] CMD_RD_TERM = 8'h08;
    localparam logic [7:0] FILL_BYTE   = 8'h00;

    typedef enum logic [1:0] {
        TERM_NONE = 2'd0,
        TERM_WR   = 2'd1,
        TERM_RD   = 2'd2
    } term_e;

    function automatic term_e decode_term(input logic vld, input logic [7:0] code);
        term_e k;
        k = TERM_NONE;
        if (vld && code == CMD_WR_TERM) k = TERM_WR;
        if (vld && code == CMD_RD_TERM) k = TERM_RD;
        return k;
    endfunction

endpackage

// File: rtl/seg_slot.sv
module seg_slot #(
    parameter int BASE_W = 12,
    parameter int LEN_W  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BASE_W-1:0] ld_base,
    input  logic [LEN_W-1:0]  ld_len,
    input  logic              retire,
    output logic              act_valid,
    output logic [BASE_W-1:0] act_base,
    output logic [LEN_W-1:0]  act_len,
    output logic              ready
);
    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [LEN_W-1:0]  len;
    } desc_t;

    desc_t act_q, pend_q;
    logic  act_v_q, pend_v_q;
    logic  act_keep;

    assign act_keep = act_v_q && !retire;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_v_q  <= 1'b0;
            pend_v_q <= 1'b0;
            act_q    <= '0;
            pend_q   <= '0;
        end else begin
            if (!act_keep && pend_v_q) begin
                act_v_q  <= 1'b1;
                act_q    <= pend_q;
                pend_v_q <= 1'b0;
            end else begin
                act_v_q <= act_keep;
                if (load && !pend_v_q) begin
                    pend_v_q <= 1'b1;
                    pend_q   <= '{base: ld_base, len: ld_len};
                end
            end
        end
    end

    assign act_valid = act_v_q;
    assign act_base  = act_q.base;
    assign act_len   = act_q.len;
    assign ready     = !pend_v_q;

    a_r9_load_busy: assert property (@(posedge clk) disable iff (rst)
        (load && ready) |=> !ready);
    a_r9_act_kept: assert property (@(posedge clk) disable iff (rst)
        (act_valid && !retire) |=> (act_valid && $stable(act_base) && $stable(act_len)));
endmodule

// File: rtl/seg_rd_stream.sv
module seg_rd_stream
    import seg_dma_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int LEN_W  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              act_valid,
    input  logic [ADDR_W-1:0] act_base,
    input  logic [LEN_W-1:0]  act_len,
    input  logic              restart,
    input  logic              req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_data,
    output logic [7:0]        out_data,
    output logic              out_vld,
    output logic              out_fill,
    output logic              done
);
    localparam logic [LEN_W-1:0] PTR_MAX = '1;

    logic [LEN_W-1:0] ptr_q;
    logic             in_range;

    assign in_range = act_valid && (ptr_q < act_len);
    assign mem_addr = act_base + ADDR_W'(ptr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q    <= '0;
            out_data <= FILL_BYTE;
            out_vld  <= 1'b0;
            out_fill <= 1'b0;
            done     <= 1'b0;
        end else begin
            done    <= restart;
            out_vld <= req && !restart;
            if (req) begin
                out_data <= in_range ? mem_data : FILL_BYTE;
                out_fill <= !in_range;
            end
            if (restart)
                ptr_q <= '0;
            else if (req && act_valid && ptr_q != PTR_MAX)
                ptr_q <= ptr_q + 1'b1;
        end
    end

    a_r2_rd_ack: assert property (@(posedge clk) disable iff (rst)
        (req && !restart) |=> out_vld);
    a_r3_fill_zero: assert property (@(posedge clk) disable iff (rst)
        (out_vld && out_fill) |-> (out_data == FILL_BYTE));
    a_r5_restart_ptr: assert property (@(posedge clk) disable iff (rst)
        restart |=> (ptr_q == '0 && done));
    a_r4_no_buf_hold: assert property (@(posedge clk) disable iff (rst)
        (!act_valid && !restart) |=> $stable(ptr_q));
endmodule

// File: rtl/seg_wr_stream.sv
module seg_wr_stream #(
    parameter int ADDR_W = 12,
    parameter int LEN_W  = 13,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              act_valid,
    input  logic [ADDR_W-1:0] act_base,
    input  logic [LEN_W-1:0]  act_len,
    input  logic              restart,
    input  logic              in_vld,
    input  logic [7:0]        in_byte,
    output logic              mem_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_data,
    output logic              done,
    output logic [CNT_W-1:0]  done_cnt,
    output logic              overflow
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [LEN_W-1:0] ptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             accept;

    assign accept = in_vld && !restart && act_valid && (ptr_q < act_len);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q    <= '0;
            cnt_q    <= '0;
            mem_en   <= 1'b0;
            mem_addr <= '0;
            mem_data <= '0;
            done     <= 1'b0;
            done_cnt <= '0;
            overflow <= 1'b0;
        end else begin
            mem_en <= accept;
            done   <= restart;
            if (accept) begin
                mem_addr <= act_base + ADDR_W'(ptr_q);
                mem_data <= in_byte;
            end
            if (in_vld && !restart && !accept)
                overflow <= 1'b1;
            if (restart) begin
                done_cnt <= cnt_q;
                cnt_q    <= '0;
                ptr_q    <= '0;
            end else begin
                if (accept)
                    ptr_q <= ptr_q + 1'b1;
                if (in_vld && cnt_q != CNT_MAX)
                    cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    a_r7_sticky_overflow: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);
    a_r8_done_clears_count: assert property (@(posedge clk) disable iff (rst)
        done |-> (cnt_q == '0 && ptr_q == '0));
    a_r6_write_has_cause: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> $past(in_vld && act_valid));
    a_r7_no_buf_no_write: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !act_valid) |=> !mem_en);
endmodule

// File: rtl/seg_dma_seq.sv
module seg_dma_seq
    import seg_dma_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int LEN_W  = 13,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_code,
    input  logic              rd_req,
    output logic [7:0]        rd_data,
    output logic              rd_vld,
    output logic              rd_fill,
    input  logic              wr_valid,
    input  logic [7:0]        wr_byte,
    input  logic              host_rd_load,
    input  logic [ADDR_W-1:0] host_rd_base,
    input  logic [LEN_W-1:0]  host_rd_len,
    output logic              host_rd_ready,
    input  logic              host_wr_load,
    input  logic [ADDR_W-1:0] host_wr_base,
    input  logic [LEN_W-1:0]  host_wr_len,
    output logic              host_wr_ready,
    output logic              rd_done,
    output logic              wr_done,
    output logic [CNT_W-1:0]  wr_done_count,
    output logic              wr_overflow,
    output logic [ADDR_W-1:0] rdmem_addr,
    input  logic [7:0]        rdmem_data,
    output logic              wrmem_en,
    output logic [ADDR_W-1:0] wrmem_addr,
    output logic [7:0]        wrmem_data
);
    term_e            term;
    logic             rd_term, wr_term;
    logic             rd_act_v, wr_act_v;
    logic [ADDR_W-1:0] rd_act_base, wr_act_base;
    logic [LEN_W-1:0]  rd_act_len, wr_act_len;

    assign term    = decode_term(cmd_valid, cmd_code);
    assign rd_term = (term == TERM_RD);
    assign wr_term = (term == TERM_WR);

    seg_slot #(.BASE_W(ADDR_W), .LEN_W(LEN_W)) u_rd_slot (
        .clk(clk), .rst(rst),
        .load(host_rd_load), .ld_base(host_rd_base), .ld_len(host_rd_len),
        .retire(rd_term),
        .act_valid(rd_act_v), .act_base(rd_act_base), .act_len(rd_act_len),
        .ready(host_rd_ready)
    );

    seg_slot #(.BASE_W(ADDR_W), .LEN_W(LEN_W)) u_wr_slot (
        .clk(clk), .rst(rst),
        .load(host_wr_load), .ld_base(host_wr_base), .ld_len(host_wr_len),
        .retire(wr_term),
        .act_valid(wr_act_v), .act_base(wr_act_base), .act_len(wr_act_len),
        .ready(host_wr_ready)
    );

    seg_rd_stream #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_rd (
        .clk(clk), .rst(rst),
        .act_valid(rd_act_v), .act_base(rd_act_base), .act_len(rd_act_len),
        .restart(rd_term), .req(rd_req),
        .mem_addr(rdmem_addr), .mem_data(rdmem_data),
        .out_data(rd_data), .out_vld(rd_vld), .out_fill(rd_fill),
        .done(rd_done)
    );

    seg_wr_stream #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_wr (
        .clk(clk), .rst(rst),
        .act_valid(wr_act_v), .act_base(wr_act_base), .act_len(wr_act_len),
        .restart(wr_term), .in_vld(wr_valid), .in_byte(wr_byte),
        .mem_en(wrmem_en), .mem_addr(wrmem_addr), .mem_data(wrmem_data),
        .done(wr_done), .done_cnt(wr_done_count), .overflow(wr_overflow)
    );

    a_r10_other_cmd_quiet: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code != CMD_WR_TERM && cmd_code != CMD_RD_TERM) |=> (!rd_done && !wr_done));
    a_r11_rd_term_no_wr_done: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == CMD_RD_TERM) |=> !wr_done);
endmodule

// File: tb/seg_dma_seq_test.sv
`timescale 1ns/1ps
module seg_dma_seq_test;
    localparam int AW = 6;
    localparam int LW = 7;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic [7:0] cmd_code = 8'h00;
    logic rd_req = 1'b0;
    logic [7:0] rd_data;
    logic rd_vld, rd_fill;
    logic wr_valid = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic host_rd_load = 1'b0;
    logic [AW-1:0] host_rd_base = '0;
    logic [LW-1:0] host_rd_len = '0;
    logic host_rd_ready;
    logic host_wr_load = 1'b0;
    logic [AW-1:0] host_wr_base = '0;
    logic [LW-1:0] host_wr_len = '0;
    logic host_wr_ready;
    logic rd_done, wr_done, wr_overflow;
    logic [CW-1:0] wr_done_count;
    logic [AW-1:0] rdmem_addr;
    logic [7:0] rdmem_data;
    logic wrmem_en;
    logic [AW-1:0] wrmem_addr;
    logic [7:0] wrmem_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    assign rdmem_data = 8'(rdmem_addr) * 8'd7 + 8'd3;

    seg_dma_seq #(.ADDR_W(AW), .LEN_W(LW), .CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .rd_req(rd_req), .rd_data(rd_data), .rd_vld(rd_vld), .rd_fill(rd_fill),
        .wr_valid(wr_valid), .wr_byte(wr_byte),
        .host_rd_load(host_rd_load), .host_rd_base(host_rd_base), .host_rd_len(host_rd_len),
        .host_rd_ready(host_rd_ready),
        .host_wr_load(host_wr_load), .host_wr_base(host_wr_base), .host_wr_len(host_wr_len),
        .host_wr_ready(host_wr_ready),
        .rd_done(rd_done), .wr_done(wr_done), .wr_done_count(wr_done_count),
        .wr_overflow(wr_overflow), .rdmem_addr(rdmem_addr), .rdmem_data(rdmem_data),
        .wrmem_en(wrmem_en), .wrmem_addr(wrmem_addr), .wrmem_data(wrmem_data)
    );

    function automatic logic [7:0] mem_val(input int a);
        return 8'((a % 64) * 7 + 3);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // read n bytes; offsets start..start+n-1; len<0 means no buffer
    task automatic rd_txn(input string tag, input int n, input int base, input int len, input int start);
        for (int i = 0; i < n; i++) begin
            int off;
            logic [7:0] ed;
            logic ef;
            off = start + i;
            ef = !(len >= 0 && off < len);
            ed = ef ? 8'h00 : mem_val(base + off);
            rd_req = 1'b1;
            tick();
            chk(tag, {rd_vld, rd_fill, rd_data}, {1'b1, ef, ed});
        end
        rd_req = 1'b0;
        tick();
    endtask

    task automatic wr_txn(input string tag, input int n, input int base, input int len, input int start);
        for (int i = 0; i < n; i++) begin
            int off;
            logic [7:0] b;
            off = start + i;
            b = 8'(off * 5 + 1);
            wr_valid = 1'b1;
            wr_byte = b;
            tick();
            if (len >= 0 && off < len)
                chk(tag, {wrmem_en, 2'b00, wrmem_addr, wrmem_data},
                    {1'b1, 2'b00, 6'((base + off) % 64), b});
            else
                chk(tag, {31'd0, wrmem_en}, 32'd0);
        end
        wr_valid = 1'b0;
        tick();
    endtask

    task automatic send_cmd(input logic [7:0] c);
        cmd_valid = 1'b1;
        cmd_code = c;
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic load_rd(input int base, input int len);
        host_rd_load = 1'b1;
        host_rd_base = 6'(base);
        host_rd_len = 7'(len);
        tick();
        host_rd_load = 1'b0;
    endtask

    task automatic load_wr(input int base, input int len);
        host_wr_load = 1'b1;
        host_wr_base = 6'(base);
        host_wr_len = 7'(len);
        tick();
        host_wr_load = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 ready", {30'd0, host_rd_ready, host_wr_ready}, 32'd3);
        chk("R1 outputs", {27'd0, rd_vld, rd_done, wr_done, wrmem_en, wr_overflow}, 32'd0);

        // R4 read without buffer
        rd_txn("R4 no buffer", 3, 0, -1, 0);

        // R9 handshake: load into idle direction
        load_rd(10, 20);
        chk("R9 ready low after load", {31'd0, host_rd_ready}, 32'd0);
        tick();
        chk("R9 promoted", {31'd0, host_rd_ready}, 32'd1);
        load_rd(40, 5);
        chk("R9 pending busy", {31'd0, host_rd_ready}, 32'd0);
        load_rd(0, 9);  // ignored: not ready
        chk("R9 still busy", {31'd0, host_rd_ready}, 32'd0);

        // R2 / R3 segmented reads, offset kept across gaps (R4 offset held when idle)
        for (int t = 0; t < 4; t++)
            rd_txn("R2 R3 segmented read", 6, 10, 20, t * 6);

        // R5 termination arms pending buffer
        send_cmd(8'h08);
        chk("R5 rd_done pulse", {30'd0, rd_done, wr_done}, 32'd2);
        chk("R5 next armed", {31'd0, host_rd_ready}, 32'd1);
        tick();
        chk("R5 rd_done one cycle", {31'd0, rd_done}, 32'd0);
        rd_txn("R5 R3 second buffer", 7, 40, 5, 0);

        // R5 no pending: R9 ignored load must not appear
        send_cmd(8'h08);
        chk("R5 rd_done again", {31'd0, rd_done}, 32'd1);
        rd_txn("R5 R9 nothing armed", 3, 0, -1, 0);

        // R3 sweep over lengths
        for (int L = 1; L <= 6; L++) begin
            load_rd(L * 9, L);
            tick();
            rd_txn("R3 length sweep", L + 2, L * 9, L, 0);
            send_cmd(8'h08);
        end

        // R10 unrelated command
        load_rd(5, 10);
        tick();
        rd_txn("R10 before", 2, 5, 10, 0);
        send_cmd(8'h55);
        chk("R10 no done", {30'd0, rd_done, wr_done}, 32'd0);
        // R11 write termination keeps read offset
        send_cmd(8'h07);
        chk("R11 wr_done only", {30'd0, rd_done, wr_done}, 32'd1);
        rd_txn("R10 R11 offset kept", 3, 5, 10, 2);
        send_cmd(8'h08);

        // R7 writes without buffer
        wr_txn("R7 no buffer", 2, 0, -1, 0);
        chk("R7 overflow set", {31'd0, wr_overflow}, 32'd1);
        send_cmd(8'h07);
        chk("R8 count dropped", {23'd0, wr_done, wr_done_count}, {23'd0, 1'b1, 8'd2});

        // R6 wrapping buffer, R11 read termination mid-stream
        load_wr(60, 8);
        tick();
        wr_txn("R6 wrap", 3, 60, 8, 0);
        send_cmd(8'h08);
        chk("R11 rd term no wr_done", {30'd0, rd_done, wr_done}, 32'd2);
        wr_txn("R6 R11 continue", 3, 60, 8, 3);
        wr_txn("R6 R7 past end", 4, 60, 8, 6);
        chk("R7 overflow sticky", {31'd0, wr_overflow}, 32'd1);
        send_cmd(8'h07);
        chk("R8 count ten", {23'd0, wr_done, wr_done_count}, {23'd0, 1'b1, 8'd10});
        tick();
        chk("R8 single pulse", {31'd0, wr_done}, 32'd0);

        // R8 count restarts; R9 write handshake
        load_wr(20, 4);
        chk("R9 wr busy", {31'd0, host_wr_ready}, 32'd0);
        tick();
        wr_txn("R6 second", 3, 20, 4, 0);
        send_cmd(8'h07);
        chk("R8 count restart", {23'd0, wr_done, wr_done_count}, {23'd0, 1'b1, 8'd3});

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule